// File: doc/BRIEF.md
# Paged Data Address Translator

This block maps a 16-bit logical data address onto a 24-bit physical address. The top two bits of the logical address pick one of four page pointer registers. Each register holds a 10-bit page number. That page number is joined to the low 14 logical bits to form the physical address. The pointers are loaded through a simple write port. After reset they are set so that every logical address maps onto the same physical address.

A controller that runs an extended sequence can replace the translation for each request. A page override supplies a 10-bit page that takes the place of the selected pointer. A segment override supplies an 8-bit segment, and the whole logical address then becomes the 16-bit offset inside that segment. A word access to an odd byte address is never translated: it raises a trap instead. Results are registered and appear one clock after the request.

Top module: `dpp_xlate_top`

## Requirements
- R1: After reset, pointer k (k = 0..3) holds the value k. A request with no override therefore returns phys_o = {8'h00, addr_i}. While no result is due, all outputs read zero.
- R2: With no override, phys_o = {page pointer selected by addr_i[15:14], addr_i[13:0]}.
- R3: A write with wr_en_i loads wr_page_i into the pointer chosen by wr_sel_i. A request sampled on the same edge still uses the old value. Requests from the next edge on use the new value.
- R4: When ovr_mode_i = 2'b01 (page override), phys_o = {ovr_page_i, addr_i[13:0]}, whatever the pointers hold.
- R5: When ovr_mode_i = 2'b10 (segment override), phys_o = {ovr_seg_i, addr_i[15:0]}.
- R6: A word access (word_i = 1) with addr_i[0] = 1 sets trap_o, keeps done_o low and drives phys_o to zero for that result.
- R7: A byte access (word_i = 0) never traps at any address, even or odd. It completes with done_o = 1.
- R8: Each request sampled with req_i = 1 produces exactly one result on the next clock edge: done_o or trap_o, never both. A cycle with req_i = 0 produces done_o = 0, trap_o = 0 and phys_o = 0.
- R9: The code ovr_mode_i = 2'b11 behaves exactly like 2'b00 (no override).
- R10: The alignment trap takes priority over both override modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Pointer write strobe |
| wr_sel_i | input | 2 | Index of the pointer to write |
| wr_page_i | input | 10 | Page value to write |
| req_i | input | 1 | Translation request |
| addr_i | input | 16 | Logical address |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| ovr_mode_i | input | 2 | 00 none, 01 page override, 10 segment override, 11 none |
| ovr_page_i | input | 10 | Override page number |
| ovr_seg_i | input | 8 | Override segment number |
| done_o | output | 1 | Translation completed (one clock after the request) |
| trap_o | output | 1 | Odd word access trapped (one clock after the request) |
| phys_o | output | 24 | Physical address, zero unless done_o |

## Verification
Every result is due on the first rising edge after its request is sampled. Pointer writes affect only requests sampled on a later edge. The bench drives inputs on the falling edge and computes the expected result from the model state as it stood before that cycle's write. It compares at the next falling edge, one register stage later. Requests that coincide with a write are issued on purpose, so the old and new pointer values are each checked in the cycle where they apply.

// File: rtl/dpp_xlate_pkg.sv
package dpp_xlate_pkg;
  typedef enum logic [1:0] {
    OVR_NONE = 2'b00,
    OVR_PAGE = 2'b01,
    OVR_SEG  = 2'b10,
    OVR_RSVD = 2'b11
  } ovr_mode_e;
endpackage

// File: rtl/dpp_ptr_bank.sv
module dpp_ptr_bank #(
  parameter int NUM_PTR = 4,
  parameter int PAGE_W  = 10,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [PAGE_W-1:0]              wr_page_i,
  output logic [NUM_PTR-1:0][PAGE_W-1:0] pages_o
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    // reset value g gives an identity mapping
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  pages_o[g] <= PAGE_W'(g);
      else if (wr_en_i && wr_sel_i == SEL_W'(g))    pages_o[g] <= wr_page_i;
    end
  end
endmodule

// File: rtl/dpp_addr_map.sv
module dpp_addr_map
  import dpp_xlate_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int PAGE_W  = 10,
  parameter int SEG_W   = 8,
  parameter int LOG_W   = 16,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int OFS_W  = LOG_W - SEL_W,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic [LOG_W-1:0]               addr_i,
  input  logic [NUM_PTR-1:0][PAGE_W-1:0] pages_i,
  input  ovr_mode_e                      mode_i,
  input  logic [PAGE_W-1:0]              ovr_page_i,
  input  logic [SEG_W-1:0]               ovr_seg_i,
  output logic [PHYS_W-1:0]              phys_o
);
  logic [SEL_W-1:0]  sel;
  logic [OFS_W-1:0]  ofs;
  logic [PAGE_W-1:0] page;

  assign sel = addr_i[LOG_W-1 -: SEL_W];
  assign ofs = addr_i[OFS_W-1:0];

  always_comb begin
    page = (mode_i == OVR_PAGE) ? ovr_page_i : pages_i[sel];
    if (mode_i == OVR_SEG) phys_o = PHYS_W'({ovr_seg_i, addr_i});
    else                   phys_o = {page, ofs};
  end
endmodule

// File: rtl/dpp_align_chk.sv
module dpp_align_chk (
  input  logic word_i,
  input  logic addr_lsb_i,
  output logic misaligned_o
);
  assign misaligned_o = word_i & addr_lsb_i;
endmodule

// File: rtl/dpp_xlate_top.sv
module dpp_xlate_top
  import dpp_xlate_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int PAGE_W  = 10,
  parameter int SEG_W   = 8,
  parameter int LOG_W   = 16,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int PHYS_W = PAGE_W + LOG_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic              req_i,
  input  logic [LOG_W-1:0]  addr_i,
  input  logic              word_i,
  input  logic [1:0]        ovr_mode_i,
  input  logic [PAGE_W-1:0] ovr_page_i,
  input  logic [SEG_W-1:0]  ovr_seg_i,
  output logic              done_o,
  output logic              trap_o,
  output logic [PHYS_W-1:0] phys_o
);
  logic [NUM_PTR-1:0][PAGE_W-1:0] pages;
  logic [PHYS_W-1:0]              phys_d;
  logic                           misaligned;

  dpp_ptr_bank #(.NUM_PTR(NUM_PTR), .PAGE_W(PAGE_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_page_i, .pages_o(pages)
  );

  dpp_addr_map #(.NUM_PTR(NUM_PTR), .PAGE_W(PAGE_W), .SEG_W(SEG_W), .LOG_W(LOG_W)) u_map (
    .addr_i, .pages_i(pages), .mode_i(ovr_mode_e'(ovr_mode_i)),
    .ovr_page_i, .ovr_seg_i, .phys_o(phys_d)
  );

  dpp_align_chk u_align (.word_i, .addr_lsb_i(addr_i[0]), .misaligned_o(misaligned));

  // result register: old pointer values apply to requests on the write edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      trap_o <= 1'b0;
      phys_o <= '0;
    end else begin
      done_o <= req_i & ~misaligned;
      trap_o <= req_i &  misaligned;
      phys_o <= (req_i && !misaligned) ? phys_d : '0;
    end
  end
endmodule

// File: rtl/dpp_xlate_chk.sv
module dpp_xlate_chk #(
  parameter int PAGE_W = 10,
  parameter int SEG_W  = 8,
  parameter int LOG_W  = 16,
  parameter int SEL_W  = 2,
  parameter int PHYS_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [LOG_W-1:0]  addr_i,
  input logic              word_i,
  input logic [1:0]        ovr_mode_i,
  input logic [PAGE_W-1:0] ovr_page_i,
  input logic [SEG_W-1:0]  ovr_seg_i,
  input logic              done_o,
  input logic              trap_o,
  input logic [PHYS_W-1:0] phys_o
);
  localparam int OFS_W = LOG_W - SEL_W;

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && !trap_o && phys_o == '0));

  assert_one_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $onehot({done_o, trap_o}));

  assert_odd_word_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && word_i && addr_i[0]) |=> (trap_o && !done_o && phys_o == '0));

  assert_byte_no_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !word_i) |=> (done_o && !trap_o));

  assert_page_ovr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(word_i && addr_i[0]) && ovr_mode_i == 2'b01) |=>
      (phys_o == {$past(ovr_page_i), $past(addr_i[OFS_W-1:0])}));

  assert_seg_ovr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(word_i && addr_i[0]) && ovr_mode_i == 2'b10) |=>
      (phys_o == PHYS_W'({$past(ovr_seg_i), $past(addr_i)})));

  assert_trap_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && word_i && addr_i[0] && ovr_mode_i != 2'b00) |=> trap_o);
endmodule

bind dpp_xlate_top dpp_xlate_chk #(
  .PAGE_W(PAGE_W), .SEG_W(SEG_W), .LOG_W(LOG_W), .SEL_W(SEL_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .word_i(word_i),
  .ovr_mode_i(ovr_mode_i), .ovr_page_i(ovr_page_i), .ovr_seg_i(ovr_seg_i),
  .done_o(done_o), .trap_o(trap_o), .phys_o(phys_o)
);

// File: tb/sim_dpp_xlate_top.sv
`timescale 1ns/1ps
module sim_dpp_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, req, word;
  logic [1:0]  wr_sel, mode;
  logic [9:0]  wr_page, ovr_page;
  logic [15:0] addr;
  logic [7:0]  ovr_seg;
  logic        done, trap;
  logic [23:0] phys;

  int checks = 0;
  int fails  = 0;
  int ptr [4];
  logic        e_done = 1'b0, e_trap = 1'b0;
  logic [23:0] e_phys = '0;
  string       e_tag  = "R1";

  always #5 clk = ~clk;

  dpp_xlate_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_page_i(wr_page),
    .req_i(req), .addr_i(addr), .word_i(word), .ovr_mode_i(mode),
    .ovr_page_i(ovr_page), .ovr_seg_i(ovr_seg),
    .done_o(done), .trap_o(trap), .phys_o(phys)
  );

  task automatic compare();
    checks++;
    if (done !== e_done || trap !== e_trap || phys !== e_phys) begin
      fails++;
      $display("FAIL %s: done/trap/phys got %b/%b/%06h expected %b/%b/%06h",
               e_tag, done, trap, phys, e_done, e_trap, e_phys);
    end
  endtask

  task automatic step(input string tag, input logic rq, input logic [15:0] a,
                      input logic w, input logic [1:0] m, input logic [9:0] pg,
                      input logic [7:0] sg, input logic we, input logic [1:0] ws,
                      input logic [9:0] wd);
    @(negedge clk);
    compare();
    req = rq; addr = a; word = w; mode = m; ovr_page = pg; ovr_seg = sg;
    wr_en = we; wr_sel = ws; wr_page = wd;
    e_tag = tag;
    if (!rq) begin
      e_done = 0; e_trap = 0; e_phys = '0;
    end else if (w && a[0]) begin
      e_done = 0; e_trap = 1; e_phys = '0;
    end else begin
      e_done = 1; e_trap = 0;
      case (m)
        2'b01:   e_phys = {pg, a[13:0]};
        2'b10:   e_phys = {sg, a};
        default: e_phys = {10'(ptr[a[15:14]]), a[13:0]};
      endcase
    end
    if (we) ptr[ws] = int'(wd);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 16'h0, 0, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) ptr[k] = k;
    rst_n = 0; wr_en = 0; req = 0; word = 0; mode = 0;
    wr_sel = 0; wr_page = 0; ovr_page = 0; ovr_seg = 0; addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: identity mapping from reset values (first compare checks reset outputs)
    for (int k = 0; k < 4; k++)
      step("R1", 1, {2'(k), 14'h1a5b}, 0, 2'b00, 10'h3ff, 8'hff, 0, 2'b00, 10'h0);
    step("R1", 1, 16'hfffe, 1, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    idle("R8");
    // R7: byte accesses at odd and even addresses
    step("R7", 1, 16'h4001, 0, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    step("R7", 1, 16'hffff, 0, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    step("R7", 1, 16'h8000, 0, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    // R6 / R10: odd word traps, with and without overrides
    step("R6", 1, 16'h2003, 1, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    step("R10", 1, 16'hc001, 1, 2'b01, 10'h155, 8'h0, 0, 2'b00, 10'h0);
    step("R10", 1, 16'h7fff, 1, 2'b10, 10'h0, 8'h5a, 0, 2'b00, 10'h0);
    // R3: write with same-cycle request, then request again
    step("R3", 1, 16'h8123, 1, 2'b00, 10'h0, 8'h0, 1, 2'b10, 10'h3a5);
    step("R3", 1, 16'h8123, 1, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    step("R3", 1, 16'h0456, 0, 2'b00, 10'h0, 8'h0, 1, 2'b00, 10'h2c1);
    step("R3", 1, 16'h0456, 0, 2'b00, 10'h0, 8'h0, 0, 2'b00, 10'h0);
    // R4 / R5 / R9: override modes
    step("R4", 1, 16'hc246, 1, 2'b01, 10'h2aa, 8'h11, 0, 2'b00, 10'h0);
    step("R4", 1, 16'h3fff, 0, 2'b01, 10'h001, 8'h11, 0, 2'b00, 10'h0);
    step("R5", 1, 16'hbeee, 1, 2'b10, 10'h2aa, 8'hc3, 0, 2'b00, 10'h0);
    step("R5", 1, 16'h0001, 0, 2'b10, 10'h000, 8'hff, 0, 2'b00, 10'h0);
    step("R9", 1, 16'h8124, 1, 2'b11, 10'h111, 8'h22, 0, 2'b00, 10'h0);
    step("R9", 1, 16'h4321, 0, 2'b11, 10'h111, 8'h22, 0, 2'b00, 10'h0);
    // R8: idle cycles with busy inputs must stay quiet
    step("R8", 0, 16'hffff, 1, 2'b10, 10'h3ff, 8'hff, 0, 2'b00, 10'h0);
    step("R8", 0, 16'h1235, 0, 2'b01, 10'h3ff, 8'hff, 0, 2'b00, 10'h0);
    // R2: random pointers and aligned requests without override
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      logic        w;
      a = 16'($urandom);
      w = 1'($urandom);
      if (w) a[0] = 1'b0;
      step("R2", 1, a, w, 2'b00, 10'($urandom), 8'($urandom),
           1'($urandom), 2'($urandom), 10'($urandom));
    end
    // mixed traffic across all modes
    for (int i = 0; i < 150; i++)
      step("R8", 1'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
           10'($urandom), 8'($urandom), 1'($urandom), 2'($urandom), 10'($urandom));
    idle("R8");
    idle("R8");
    @(negedge clk);
    compare();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule